// File: doc/BRIEF.md
# Converter Acquisition Sequencer

This block is a bus master for a two-step 8-bit analog-to-digital converter that has a parallel data port. On a start pulse it selects the converter with an active-low chip select. It then runs one of two strobe sequences and latches the byte from the converter's data bus. The byte goes to user logic over a valid/ready stream port.

The `mode_i` input picks the sequence. In the read-only sequence (`mode_i` = 0) the controller lowers the read strobe and holds it low. The converter pulls its ready line low once selected and releases it when the conversion ends, and the controller waits for that release. In the write-read sequence (`mode_i` = 1) the controller first pulses the write strobe low. It then waits for the converter's active-low interrupt before it lowers the read strobe.

Chip-select setup, chip-select hold, write pulse width, access delay and timeout are parameters counted in clocks. A power-down request parks the converter in its sleep state. The stream port follows the usual rule: a byte stays on `out_data_o` with `out_valid_o` high until a cycle in which `out_ready_i` is high. While a byte is waiting, no new acquisition can start.

Top module: `cnv_reader`

## Requirements
- R1: While reset is low and right after it, `cs_n_o`, `rd_n_o`, `wr_n_o` and `pwrdn_n_o` are 1, and `out_valid_o` and `err_o` are 0.
- R2: A start accepted with `mode_i` = 0 lowers `cs_n_o`, drives `mode_o` = 0, lowers `rd_n_o` and keeps it low until `rdy_i` has been seen 0 after chip select fell and is then seen 1.
- R3: A start accepted with `mode_i` = 1 drives `mode_o` = 1 and holds `wr_n_o` low for exactly WR_CLKS cycles. After `wr_n_o` rises, `rd_n_o` stays high until `int_n_i` is seen 0.
- R4: Once readiness is seen with the read strobe low, `rd_n_o` stays low for exactly ACC_CLKS more cycles. The byte on `bus_i` is latched at the end of that window and offered on `out_data_o`.
- R5: `cs_n_o` is low for exactly SETUP_CLKS cycles before the first strobe falls. It stays low for exactly HOLD_CLKS cycles after the last strobe rises.
- R6: If readiness does not arrive within TIMEOUT_CLKS cycles of waiting, both strobes are released and chip select rises after the hold interval. `err_o` becomes 1 and no byte is offered. `err_o` clears when the next start is accepted.
- R7: A start pulse is ignored while a transaction is in progress, while a byte waits on the stream port, and during power-down.
- R8: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_valid_o` stays 1 and `out_data_o` is unchanged. With `out_ready_i` held at 1 the byte is offered for a single cycle.
- R9: A power-down request seen while idle drives `pwrdn_n_o` = 0, `mode_o` = 0 and all three strobes high, one clock later. Dropping the request returns the block to idle one clock later.
- R10: `rd_n_o` and `wr_n_o` are never low together, and neither is ever low while `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Acquisition request, sampled in idle |
| mode_i | input | 1 | 0 = read-only sequence, 1 = write-read sequence |
| pwrdn_req_i | input | 1 | Hold the converter in power-down |
| cs_n_o | output | 1 | Converter chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| mode_o | output | 1 | Converter interface-mode pin |
| pwrdn_n_o | output | 1 | Converter sleep control, low = sleep |
| int_n_i | input | 1 | Converter end-of-conversion, active low |
| rdy_i | input | 1 | Converter ready line (pulled up, 1 = released) |
| bus_i | input | DATA_W | Converter data bus |
| out_valid_o | output | 1 | Stream valid |
| out_ready_i | input | 1 | Stream ready |
| out_data_o | output | DATA_W | Captured byte |
| err_o | output | 1 | Last transaction timed out |

## Verification
The strobes and chip select come straight from the state register, so each one moves in the clock after the edge that changes state. Power-down entry and exit therefore show up one clock after the request changes. The byte and `out_valid_o` appear in the first cycle of the hold interval. That is one edge after the last access cycle, which itself comes ACC_CLKS cycles after readiness is sampled. A converter model in the bench drives the inputs on the falling clock edge and counts, on the same edges, the cycles spent in setup, write pulse, access and hold. Those counts are compared with the parameters once chip select rises. Byte and error results are taken from the stream port during the transaction and checked once the transaction is over.

// File: rtl/cnv_reader_pkg.sv
package cnv_reader_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SLEEP,
    S_SETUP,
    S_WRP,
    S_WINT,
    S_RDW,
    S_ACC,
    S_HOLD
  } cnv_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cnv_reader_timer.sv
module cnv_reader_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val != '0) |=> !zero);

endmodule

// File: rtl/cnv_reader_out.sv
module cnv_reader_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         rd_n,
  input  logic [W-1:0] bus,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (cap_en) begin
      valid <= 1'b1;
      data  <= bus;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R4
  cap_under_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !rd_n);

  // R8
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));

endmodule

// File: rtl/cnv_reader.sv
module cnv_reader
  import cnv_reader_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SETUP_CLKS   = 1,
  parameter int HOLD_CLKS    = 1,
  parameter int ACC_CLKS     = 2,
  parameter int WR_CLKS      = 2,
  parameter int TIMEOUT_CLKS = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              pwrdn_req_i,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              mode_o,
  output logic              pwrdn_n_o,
  input  logic              int_n_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);

  localparam int PH_MAX = max2(max2(SETUP_CLKS, HOLD_CLKS), max2(ACC_CLKS, WR_CLKS));
  localparam int PH_W   = (PH_MAX < 2) ? 1 : $clog2(PH_MAX);
  localparam int TO_W   = (TIMEOUT_CLKS < 2) ? 1 : $clog2(TIMEOUT_CLKS);

  cnv_state_e st, nxt;
  logic mode_r, seen_low, err_r;
  logic ph_load, ph_zero, to_load, to_zero;
  logic [PH_W-1:0] ph_val;
  logic abort, cap, accept, ready_seen;

  assign ready_seen = seen_low && rdy_i;

  always_comb begin
    nxt    = st;
    abort  = 1'b0;
    cap    = 1'b0;
    accept = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (pwrdn_req_i) nxt = S_SLEEP;
        else if (start_i && !out_valid_o) begin
          nxt    = S_SETUP;
          accept = 1'b1;
        end
      end
      S_SLEEP: if (!pwrdn_req_i) nxt = S_IDLE;
      S_SETUP: if (ph_zero) nxt = mode_r ? S_WRP : S_RDW;
      S_WRP:   if (ph_zero) nxt = S_WINT;
      S_WINT: begin
        if (!int_n_i) nxt = S_ACC;
        else if (to_zero) begin
          nxt   = S_HOLD;
          abort = 1'b1;
        end
      end
      S_RDW: begin
        if (ready_seen) nxt = S_ACC;
        else if (to_zero) begin
          nxt   = S_HOLD;
          abort = 1'b1;
        end
      end
      S_ACC: begin
        if (ph_zero) begin
          nxt = S_HOLD;
          cap = 1'b1;
        end
      end
      S_HOLD:  if (ph_zero) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    ph_load = (nxt != st);
    to_load = (nxt != st);
    unique case (nxt)
      S_SETUP: ph_val = PH_W'(SETUP_CLKS - 1);
      S_WRP:   ph_val = PH_W'(WR_CLKS - 1);
      S_ACC:   ph_val = PH_W'(ACC_CLKS - 1);
      S_HOLD:  ph_val = PH_W'(HOLD_CLKS - 1);
      default: ph_val = '0;
    endcase
  end

  cnv_reader_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  cnv_reader_timer #(.W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(to_load),
    .load_val(TO_W'(TIMEOUT_CLKS - 1)), .zero(to_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_r   <= 1'b0;
      seen_low <= 1'b0;
      err_r    <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE) mode_r <= mode_i;
      if (st == S_IDLE) seen_low <= 1'b0;
      else if (!rdy_i) seen_low <= 1'b1;
      if (accept) err_r <= 1'b0;
      else if (abort) err_r <= 1'b1;
    end
  end

  assign cs_n_o    = (st == S_IDLE) || (st == S_SLEEP);
  assign rd_n_o    = !((st == S_RDW) || (st == S_ACC));
  assign wr_n_o    = (st != S_WRP);
  assign pwrdn_n_o = (st != S_SLEEP);
  assign mode_o    = (st == S_SLEEP) ? 1'b0 : mode_r;
  assign err_o     = err_r;

  cnv_reader_out #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cap_en(cap), .rd_n(rd_n_o), .bus(bus_i),
    .ready(out_ready_i), .valid(out_valid_o), .data(out_data_o)
  );

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R10
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> !cs_n_o);

  // R9
  sleep_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n_o |-> cs_n_o && rd_n_o && wr_n_o && !mode_o);

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !cs_n_o && rd_n_o && wr_n_o && !out_valid_o);

endmodule

// File: tb/tb_cnv_reader.sv
module tb_cnv_reader;

  localparam int SETUP = 2, HOLD = 3, ACC = 2, WRW = 2, TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0, pwrdn_req_i = 1'b0, out_ready_i = 1'b1;
  logic int_n_i = 1'b1, rdy_i = 1'b1;
  logic [7:0] bus_i = 8'h00;
  logic cs_n_o, rd_n_o, wr_n_o, mode_o, pwrdn_n_o, out_valid_o, err_o;
  logic [7:0] out_data_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cnv_reader #(.DATA_W(8), .SETUP_CLKS(SETUP), .HOLD_CLKS(HOLD), .ACC_CLKS(ACC),
               .WR_CLKS(WRW), .TIMEOUT_CLKS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .pwrdn_req_i(pwrdn_req_i), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .mode_o(mode_o), .pwrdn_n_o(pwrdn_n_o), .int_n_i(int_n_i), .rdy_i(rdy_i),
    .bus_i(bus_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .err_o(err_o)
  );

  // converter model and interval monitor, both on the falling edge
  logic       mdl_mode = 1'b0;
  int         mdl_lat = 1;
  logic [7:0] mdl_data = 8'h00;
  int  m_cnt = 0, setup_c = 0, hold_c = 0, acc_c = 0, wr_c = 0, cs_falls = 0;
  bit  m_done = 0, m_wr_seen = 0, strobe_seen = 0, cs_low_prev = 0, rd_prev_low = 0;
  bit  mode_seen = 0;

  always @(negedge clk) begin
    if (!cs_n_o) begin
      if (!cs_low_prev) begin
        setup_c = 0; hold_c = 0; acc_c = 0; wr_c = 0; strobe_seen = 0;
        cs_falls++;
        mode_seen = mode_o;
      end
      if (rd_n_o && wr_n_o) begin
        if (!strobe_seen) setup_c++;
        else hold_c++;
      end else begin
        strobe_seen = 1;
        hold_c = 0;
      end
      if (!wr_n_o) wr_c++;
      if (!rd_n_o && m_done) acc_c++;
    end
    cs_low_prev = !cs_n_o;
    if (cs_n_o) begin
      rdy_i = 1'b1; int_n_i = 1'b1; m_cnt = 0; m_done = 0; m_wr_seen = 0;
      bus_i = ~mdl_data;
    end else begin
      if (!wr_n_o) m_wr_seen = 1;
      if (!m_done) begin
        if (!mdl_mode) rdy_i = 1'b0;
        if ((!mdl_mode && !rd_n_o) || (mdl_mode && m_wr_seen && wr_n_o)) begin
          m_cnt++;
          if (m_cnt >= mdl_lat) begin
            m_done = 1; rdy_i = 1'b1; int_n_i = 1'b0; bus_i = mdl_data;
          end
        end
      end else if (rd_prev_low && rd_n_o) begin
        int_n_i = 1'b1;
      end
    end
    rd_prev_low = !rd_n_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit got;
  logic [7:0] got_d;

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    got = 0;
    got_d = 8'h00;
    for (int i = 0; i < 400; i++) begin
      if (out_valid_o && !got) begin
        got = 1;
        got_d = out_data_o;
      end
      if (cs_n_o) break;
      @(negedge clk);
    end
  endtask

  task automatic run_one(input bit m, input int lat, input logic [7:0] d, input bit experr);
    mdl_mode = m; mdl_lat = lat; mdl_data = d; mode_i = m;
    @(negedge clk);
    pulse_start();
    wait_done();
    chk(mode_seen == m, "R2/R3 mode pin", mode_seen, m);
    if (experr) begin
      chk(err_o == 1'b1, "R6 timeout err", err_o, 1);
      chk(got == 0, "R6 no byte on timeout", got, 0);
    end else begin
      chk(got == 1 && got_d == d, "R4 captured byte", got_d, d);
      chk(err_o == 1'b0, "R6 err clear", err_o, 0);
      chk(setup_c == SETUP, "R5 setup", setup_c, SETUP);
      chk(hold_c == HOLD, "R5 hold", hold_c, HOLD);
      chk(acc_c == ACC, "R4 access", acc_c, ACC);
      if (m) chk(wr_c == WRW, "R3 write width", wr_c, WRW);
      else   chk(wr_c == 0, "R2 no write strobe", wr_c, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  // {mode, latency, byte, expect timeout}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 8'd3,  8'hA5, 1'b0},
    {1'b1, 8'd4,  8'h3C, 1'b0},
    {1'b0, 8'd1,  8'h00, 1'b0},
    {1'b1, 8'd1,  8'hFF, 1'b0},
    {1'b0, 8'd60, 8'h5A, 1'b1},
    {1'b0, 8'd9,  8'h81, 1'b0},
    {1'b1, 8'd60, 8'hC3, 1'b1},
    {1'b1, 8'd39, 8'h7E, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1..R10 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(cs_n_o && rd_n_o && wr_n_o && pwrdn_n_o, "R1 strobes in reset",
        {cs_n_o, rd_n_o, wr_n_o, pwrdn_n_o}, 4'hF);
    chk(!out_valid_o && !err_o, "R1 status in reset", {out_valid_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n_o && rd_n_o && wr_n_o && !out_valid_o && !err_o, "R1 after reset",
        {cs_n_o, rd_n_o, wr_n_o, out_valid_o, err_o}, 5'b11100);

    for (int i = 0; i < 8; i++)
      run_one(VEC[i][17], int'(VEC[i][16:9]), VEC[i][8:1], VEC[i][0]);

    // R7 start ignored while busy
    begin
      int falls0;
      falls0 = cs_falls;
      mdl_mode = 0; mdl_lat = 20; mdl_data = 8'h96; mode_i = 0;
      @(negedge clk);
      pulse_start();
      repeat (6) @(negedge clk);
      mode_i = 1;
      pulse_start();
      wait_done();
      chk(got && got_d == 8'h96, "R7 first byte intact", got_d, 8'h96);
      repeat (10) @(negedge clk);
      chk(cs_n_o == 1'b1, "R7 no second transaction", cs_n_o, 1);
      chk(cs_falls - falls0 == 1, "R7 one select", cs_falls - falls0, 1);
    end

    // R8 back-pressure, R7 start ignored while byte pending
    out_ready_i = 1'b0;
    mdl_mode = 1; mdl_lat = 2; mdl_data = 8'h4D; mode_i = 1;
    @(negedge clk);
    pulse_start();
    wait_done();
    repeat (5) @(negedge clk);
    chk(out_valid_o && out_data_o == 8'h4D, "R8 byte held under stall", out_data_o, 8'h4D);
    begin
      int falls1;
      falls1 = cs_falls;
      pulse_start();
      repeat (4) @(negedge clk);
      chk(cs_falls == falls1 && cs_n_o, "R7 start ignored while pending", cs_falls - falls1, 0);
    end
    chk(out_valid_o && out_data_o == 8'h4D, "R8 still held", out_data_o, 8'h4D);
    out_ready_i = 1'b1;
    @(negedge clk);
    chk(!out_valid_o, "R8 consumed", out_valid_o, 0);

    // R9 power-down
    mode_i = 1;
    @(negedge clk) pwrdn_req_i = 1'b1;
    @(negedge clk);
    chk(!pwrdn_n_o && !mode_o && cs_n_o && rd_n_o && wr_n_o, "R9 sleep pins",
        {pwrdn_n_o, mode_o, cs_n_o, rd_n_o, wr_n_o}, 5'b00111);
    begin
      int falls2;
      falls2 = cs_falls;
      pulse_start();
      repeat (3) @(negedge clk);
      chk(cs_falls == falls2 && !pwrdn_n_o, "R7 start ignored in sleep", cs_falls - falls2, 0);
    end
    pwrdn_req_i = 1'b0;
    @(negedge clk);
    chk(pwrdn_n_o && mode_o, "R9 wake", {pwrdn_n_o, mode_o}, 2'b11);
    run_one(1'b0, 5, 8'h1E, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule